// File: doc/BRIEF.md
# Frame-Tagged Operand Belt

This block stores recent operation results as a fixed-length queue, and it takes the place of a general register file. Each cycle, the function-unit retire ports may hand over several results. The valid ones are packed in port order and pushed onto the front of the queue together. Consumers do not name a register. A read port gives an age, where position 0 is the newest value of the current frame. Every later drop adds to the age of a value already on the belt, and a value is lost once its age reaches the belt length.

Every stored entry carries the number of the frame that owns it. A call copies a short list of caller positions onto the front under the next frame number. The callee then sees only those arguments, and the caller's entries stay where they are. A return copies a list of callee positions onto the front under the caller's frame number. This works as a single multi-result operation, and it also retires every entry of the callee frame. Frame numbers are the call depth, so the caller's frame is always one below the current one. Saving caller values to memory is not part of this block. A caller value that is pushed out of the physical store during a deep call is lost.

Top module: `belt_core`

## Requirements
- R1: The belt exposes BELT_LEN positions per frame (8, 16 or 32). Once a frame has more than BELT_LEN values, its oldest value can no longer be read.
- R2: Position 0 names the newest value of the current frame. A value at position p moves to position p+n after a cycle that drops n values.
- R3: All valid retire ports drop in the same edge. The lowest-numbered valid port lands at position 0, the next at position 1, and so on. Invalid ports leave no gap.
- R4: Each read port selects its position on its own. Several ports may name the same position and return the same value in the same cycle.
- R5: A read of a position that holds no live value of the current frame raises that port's bad flag and returns zero data.
- R6: Reads are combinational on the stored state. A drop becomes visible only after the clock edge that performs it.
- R7: A call with count c (c no larger than MAX_XFER) copies the listed caller positions onto the front under frame number plus one. List entry 0 lands at position 0. The callee then sees exactly c values. A listed position that is empty copies as a live zero.
- R8: A return with count c drops the listed callee values onto the caller's belt, with list entry 0 at position 0. It retires all callee entries and lowers the frame number by one. The caller's older values reappear shifted by c.
- R9: Retire inputs are ignored in any cycle with call or return asserted. When call and return are both asserted, only the call is performed.
- R10: A call at the largest frame number and a return at frame 0 have no effect, and their retire inputs are still ignored.
- R11: After a synchronous active-low reset, the frame number is 0 and every position reads as bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ret_valid_i | input | NUM_RET | Per retire port: result present |
| ret_data_i | input | NUM_RET*DATA_W | Retire port results, port 0 in the low bits |
| call_i | input | 1 | Perform a call this cycle |
| fret_i | input | 1 | Perform a return this cycle |
| xfer_cnt_i | input | clog2(MAX_XFER+1) | Number of argument or result positions listed |
| xfer_pos_i | input | MAX_XFER*clog2(BELT_LEN) | Listed positions, list entry 0 in the low bits |
| rd_pos_i | input | NUM_RD*clog2(BELT_LEN) | Read port positions, port 0 in the low bits |
| rd_data_o | output | NUM_RD*DATA_W | Read port values |
| rd_bad_o | output | NUM_RD | Per read port: position holds no live value |
| frame_o | output | FRAME_W | Current frame number |

## Verification
A table of retire masks is driven first: a single port, the low ports, all ports, no port, alternating ports and the top port alone. These show whether packing follows port order without gaps, and whether a multi-drop shifts older values by the right amount. The rows keep filling the belt, so the oldest value is seen to fall off the end. The same position is read on several ports in one cycle. Calls and returns use repeated and empty list positions to separate copying by position from copying by slot. Retire inputs are driven during call and return cycles to show that they are ignored. A nest down to the deepest frame and back up shows the caller's values surviving untouched. It also shows that calls at the deepest frame and returns at frame 0 have no effect.

// File: rtl/belt_pkg.sv
// belt_pkg: shared types for the operand belt.
// Assumes: nothing; types only.
package belt_pkg;

    // What feeds the front of the belt in a given cycle.
    typedef enum logic [1:0] {
        DROP_IDLE   = 2'd0,
        DROP_RETIRE = 2'd1,
        DROP_CALL   = 2'd2,
        DROP_RETURN = 2'd3
    } drop_src_e;

endpackage

// File: rtl/belt_rank.sv
// belt_rank: marks the live entries owned by the current frame and gives each
// one its age rank among them (rank 0 = newest, physical slot 0 is newest).
// Assumes: slots are ordered newest first; ranks are shared by all lookups.
module belt_rank #(
    parameter int DEPTH   = 32,
    parameter int FRAME_W = 3,
    parameter int RANK_W  = $clog2(DEPTH) + 1
) (
    input  logic               live_i [DEPTH],
    input  logic [FRAME_W-1:0] tag_i  [DEPTH],
    input  logic [FRAME_W-1:0] cur_i,
    output logic [DEPTH-1:0]   elig_o,
    output logic [RANK_W-1:0]  rank_o [DEPTH]
);

    // Prefix count of current-frame entries ahead of each slot.
    always_comb begin
        int acc;
        acc = 0;
        for (int i = 0; i < DEPTH; i++) begin
            elig_o[i] = live_i[i] && (tag_i[i] == cur_i);
            rank_o[i] = RANK_W'(acc);
            if (elig_o[i]) acc++;
        end
    end

endmodule

// File: rtl/belt_lookup.sv
// belt_lookup: one temporal read port. Finds the current-frame entry whose
// rank equals the requested position and returns its value, or zero and a
// miss when no such entry exists.
// Assumes: ranks of eligible entries are distinct.
module belt_lookup #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 32,
    parameter int POS_W  = 4,
    parameter int RANK_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [DEPTH-1:0]  elig_i,
    input  logic [RANK_W-1:0] rank_i [DEPTH],
    input  logic [DATA_W-1:0] data_i [DEPTH],
    output logic [DATA_W-1:0] data_o,
    output logic              hit_o
);

    logic [DEPTH-1:0] match;

    // Match eligible slots by rank, then OR the selected value out.
    always_comb begin
        data_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            match[i] = elig_i[i] && (rank_i[i] == RANK_W'(pos_i));
            if (match[i]) data_o = data_o | data_i[i];
        end
        hit_o = |match;
    end

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R4

endmodule

// File: rtl/belt_pack.sv
// belt_pack: squeezes a sparse list of candidate drops into a dense list,
// keeping index order, and counts them.
// Assumes: candidate 0 must land nearest the belt front.
module belt_pack #(
    parameter int N      = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(N + 1)
) (
    input  logic [N-1:0]      valid_i,
    input  logic [DATA_W-1:0] data_i [N],
    output logic [DATA_W-1:0] data_o [N],
    output logic [CNT_W-1:0]  cnt_o
);

    // Place each valid candidate at the count of valid ones below it.
    always_comb begin
        int slot;
        slot = 0;
        for (int j = 0; j < N; j++) data_o[j] = '0;
        for (int p = 0; p < N; p++) begin
            if (valid_i[p]) begin
                data_o[slot] = data_i[p];
                slot++;
            end
        end
        cnt_o = CNT_W'(slot);
    end

endmodule

// File: rtl/belt_core.sv
// belt_core: frame-tagged operand belt. Physical slots hold values newest
// first; each cycle up to MAX_DROP packed values enter at slot 0 and the rest
// shift down, the last slots falling off. Reads address by age within the
// current frame. Call and return switch frame numbers without moving
// caller values.
// Assumes: xfer_cnt_i <= MAX_XFER; STORE_DEPTH >= BELT_LEN.
module belt_core #(
    parameter int BELT_LEN    = 16,
    parameter int STORE_DEPTH = 2 * BELT_LEN,
    parameter int DATA_W      = 32,
    parameter int FRAME_W     = 3,
    parameter int NUM_RET     = 4,
    parameter int NUM_RD      = 4,
    parameter int MAX_XFER    = 4,
    localparam int POS_W      = $clog2(BELT_LEN),
    localparam int XCNT_W     = $clog2(MAX_XFER + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_RET-1:0]         ret_valid_i,
    input  logic [NUM_RET*DATA_W-1:0]  ret_data_i,
    input  logic                       call_i,
    input  logic                       fret_i,
    input  logic [XCNT_W-1:0]          xfer_cnt_i,
    input  logic [MAX_XFER*POS_W-1:0]  xfer_pos_i,
    input  logic [NUM_RD*POS_W-1:0]    rd_pos_i,
    output logic [NUM_RD*DATA_W-1:0]   rd_data_o,
    output logic [NUM_RD-1:0]          rd_bad_o,
    output logic [FRAME_W-1:0]         frame_o
);
    import belt_pkg::*;

    localparam int RANK_W   = $clog2(STORE_DEPTH) + 1;
    localparam int MAX_DROP = (NUM_RET > MAX_XFER) ? NUM_RET : MAX_XFER;
    localparam int DCNT_W   = $clog2(MAX_DROP + 1);
    localparam int NUM_LK   = NUM_RD + MAX_XFER;
    localparam logic [FRAME_W-1:0] FRAME_TOP = '1;

    // Physical storage, slot 0 newest.
    logic [DATA_W-1:0]  ent_data_q [STORE_DEPTH];
    logic [FRAME_W-1:0] ent_tag_q  [STORE_DEPTH];
    logic               ent_live_q [STORE_DEPTH];
    logic [FRAME_W-1:0] frame_q;

    logic [STORE_DEPTH-1:0] elig;
    logic [RANK_W-1:0]      rank [STORE_DEPTH];

    logic [DATA_W-1:0] lk_data [NUM_LK];
    logic [NUM_LK-1:0] lk_hit;

    drop_src_e          src;
    logic               call_ok, ret_ok;
    logic [FRAME_W-1:0] new_tag;
    logic [MAX_DROP-1:0] cand_v;
    logic [DATA_W-1:0]  cand_d [MAX_DROP];
    logic [DATA_W-1:0]  pk_d   [MAX_DROP];
    logic [DCNT_W-1:0]  pk_cnt;
    logic [STORE_DEPTH-1:0] kill;

    belt_rank #(.DEPTH(STORE_DEPTH), .FRAME_W(FRAME_W), .RANK_W(RANK_W)) u_rank (
        .live_i (ent_live_q),
        .tag_i  (ent_tag_q),
        .cur_i  (frame_q),
        .elig_o (elig),
        .rank_o (rank)
    );

    // Read ports first, then the call/return list lookups.
    for (genvar k = 0; k < NUM_LK; k++) begin : g_lk
        logic [POS_W-1:0] pos;
        if (k < NUM_RD) begin : g_rd
            assign pos = rd_pos_i[k*POS_W +: POS_W];
            assign rd_data_o[k*DATA_W +: DATA_W] = lk_data[k];
            assign rd_bad_o[k] = !lk_hit[k];
        end else begin : g_xf
            assign pos = xfer_pos_i[(k-NUM_RD)*POS_W +: POS_W];
        end
        belt_lookup #(.DEPTH(STORE_DEPTH), .DATA_W(DATA_W), .POS_W(POS_W), .RANK_W(RANK_W)) u_lk (
            .clk    (clk),
            .rst_n  (rst_n),
            .pos_i  (pos),
            .elig_i (elig),
            .rank_i (rank),
            .data_i (ent_data_q),
            .data_o (lk_data[k]),
            .hit_o  (lk_hit[k])
        );
    end

    // Choose what drops this cycle: call beats return, both beat retires.
    always_comb begin
        call_ok = call_i && (frame_q != FRAME_TOP);
        ret_ok  = fret_i && !call_i && (frame_q != '0);
        if (call_i)      src = call_ok ? DROP_CALL : DROP_IDLE;
        else if (fret_i) src = ret_ok ? DROP_RETURN : DROP_IDLE;
        else             src = DROP_RETIRE;
        case (src)
            DROP_CALL:   new_tag = frame_q + 1'b1;
            DROP_RETURN: new_tag = frame_q - 1'b1;
            default:     new_tag = frame_q;
        endcase
    end

    // Build one candidate per drop lane from the selected source.
    for (genvar j = 0; j < MAX_DROP; j++) begin : g_cand
        logic rt_v, xf_v;
        logic [DATA_W-1:0] rt_d, xf_d;
        if (j < NUM_RET) begin : g_rt
            assign rt_v = ret_valid_i[j];
            assign rt_d = ret_data_i[j*DATA_W +: DATA_W];
        end else begin : g_nrt
            assign rt_v = 1'b0;
            assign rt_d = '0;
        end
        if (j < MAX_XFER) begin : g_x
            assign xf_v = XCNT_W'(j) < xfer_cnt_i;
            assign xf_d = lk_data[NUM_RD + j];
        end else begin : g_nx
            assign xf_v = 1'b0;
            assign xf_d = '0;
        end
        // Lane j candidate selection.
        always_comb begin
            case (src)
                DROP_RETIRE:            begin cand_v[j] = rt_v; cand_d[j] = rt_d; end
                DROP_CALL, DROP_RETURN: begin cand_v[j] = xf_v; cand_d[j] = xf_d; end
                default:                begin cand_v[j] = 1'b0; cand_d[j] = '0;   end
            endcase
        end
    end

    belt_pack #(.N(MAX_DROP), .DATA_W(DATA_W), .CNT_W(DCNT_W)) u_pack (
        .valid_i (cand_v),
        .data_i  (cand_d),
        .data_o  (pk_d),
        .cnt_o   (pk_cnt)
    );

    // Per slot: shift by the drop count, take packed values at the front.
    for (genvar i = 0; i < STORE_DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0]  nx_d;
        logic [FRAME_W-1:0] nx_t;
        logic               nx_l;

        assign kill[i] = (src == DROP_RETURN) && (ent_tag_q[i] == frame_q);

        // Next content of slot i.
        always_comb begin
            nx_d = ent_data_q[i];
            nx_t = ent_tag_q[i];
            nx_l = ent_live_q[i] && !kill[i];
            for (int k = 1; k <= MAX_DROP; k++) begin
                if (int'(pk_cnt) == k) begin
                    if (i >= k) begin
                        nx_d = ent_data_q[i-k];
                        nx_t = ent_tag_q[i-k];
                        nx_l = ent_live_q[i-k] && !kill[i-k];
                    end
                end
            end
            if (i < MAX_DROP) begin
                if (i < int'(pk_cnt)) begin
                    nx_d = pk_d[i % MAX_DROP];
                    nx_t = new_tag;
                    nx_l = 1'b1;
                end
            end
        end

        // Slot i register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_data_q[i] <= '0;
                ent_tag_q[i]  <= '0;
                ent_live_q[i] <= 1'b0;
            end else begin
                ent_data_q[i] <= nx_d;
                ent_tag_q[i]  <= nx_t;
                ent_live_q[i] <= nx_l;
            end
        end
    end

    // Frame number register: up on call, down on return.
    always_ff @(posedge clk) begin
        if (!rst_n)                     frame_q <= '0;
        else if (src == DROP_CALL)      frame_q <= frame_q + 1'b1;
        else if (src == DROP_RETURN)    frame_q <= frame_q - 1'b1;
    end

    assign frame_o = frame_q;

    AST_RETIRE_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        (!call_i && !fret_i && ret_valid_i[0]) |=> (ent_data_q[0] == $past(ret_data_i[DATA_W-1:0]))); // R3
    AST_CALLEE_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
        call_ok |=> ($countones(elig) == int'($past(xfer_cnt_i)))); // R7
    AST_RETURN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (fret_i && !call_i && frame_q != '0) |=> (frame_o == $past(frame_o) - 1'b1)); // R8
    AST_TOP_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && frame_o == FRAME_TOP) |=> (frame_o == FRAME_TOP)); // R10

endmodule

// File: tb/tb_belt_core.sv
module tb_belt_core;
    localparam int BL = 8, SD = 32, DW = 32, FW = 3, NR = 4, ND = 4, MX = 4;
    localparam int PW = 3, XW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NR-1:0]    ret_valid_i = '0;
    logic [NR*DW-1:0] ret_data_i = '0;
    logic call_i = 1'b0, fret_i = 1'b0;
    logic [XW-1:0]    xfer_cnt_i = '0;
    logic [MX*PW-1:0] xfer_pos_i = '0;
    logic [ND*PW-1:0] rd_pos_i = '0;
    logic [ND*DW-1:0] rd_data_o;
    logic [ND-1:0]    rd_bad_o;
    logic [FW-1:0]    frame_o;

    int nchk = 0, nfail = 0;

    // Reference model: per-frame belts, index 0 newest.
    logic [31:0] md [0:7][0:7];
    bit          mv [0:7][0:7];
    int          mf = 0;

    belt_core #(.BELT_LEN(BL), .STORE_DEPTH(SD), .DATA_W(DW), .FRAME_W(FW),
                .NUM_RET(NR), .NUM_RD(ND), .MAX_XFER(MX)) dut (
        .clk(clk), .rst_n(rst_n), .ret_valid_i(ret_valid_i), .ret_data_i(ret_data_i),
        .call_i(call_i), .fret_i(fret_i), .xfer_cnt_i(xfer_cnt_i), .xfer_pos_i(xfer_pos_i),
        .rd_pos_i(rd_pos_i), .rd_data_o(rd_data_o), .rd_bad_o(rd_bad_o), .frame_o(frame_o));

    always #5 clk = ~clk;

    typedef struct packed {
        logic [3:0]  mask;
        logic [31:0] base;
        logic [2:0]  p0, p1, p2, p3;
    } row_t;

    localparam row_t TV [10] = '{
        '{4'b0001, 32'h100, 3'd0, 3'd1, 3'd2, 3'd3},
        '{4'b0011, 32'h200, 3'd0, 3'd1, 3'd2, 3'd0},
        '{4'b1111, 32'h300, 3'd0, 3'd3, 3'd4, 3'd6},
        '{4'b0000, 32'h400, 3'd0, 3'd0, 3'd7, 3'd5},
        '{4'b0101, 32'h500, 3'd0, 3'd1, 3'd2, 3'd7},
        '{4'b1010, 32'h600, 3'd0, 3'd1, 3'd3, 3'd3},
        '{4'b1000, 32'h700, 3'd0, 3'd1, 3'd7, 3'd6},
        '{4'b1111, 32'h800, 3'd7, 3'd6, 3'd5, 3'd4},
        '{4'b0110, 32'h900, 3'd0, 3'd1, 3'd2, 3'd7},
        '{4'b1111, 32'hA00, 3'd4, 3'd5, 3'd6, 3'd7}
    };

    function automatic void mpush(int f, logic [31:0] v);
        for (int i = 7; i > 0; i--) begin
            md[f][i] = md[f][i-1];
            mv[f][i] = mv[f][i-1];
        end
        md[f][0] = v;
        mv[f][0] = 1'b1;
    endfunction

    function automatic void mclear(int f);
        for (int i = 0; i < 8; i++) begin
            mv[f][i] = 1'b0;
            md[f][i] = '0;
        end
    endfunction

    // One clocked step with model update (R7, R8, R9, R10 rules).
    task automatic step(bit c, bit r, logic [3:0] m, logic [31:0] base, int cnt,
                        int a0, int a1, int a2, int a3);
        int lst[4];
        logic [31:0] vals[4];
        lst = '{a0, a1, a2, a3};
        @(negedge clk);
        call_i = c; fret_i = r; ret_valid_i = m;
        for (int p = 0; p < NR; p++) ret_data_i[p*DW +: DW] = base + p;
        xfer_cnt_i = XW'(cnt);
        for (int j = 0; j < MX; j++) xfer_pos_i[j*PW +: PW] = PW'(lst[j]);
        for (int j = 0; j < 4; j++) vals[j] = mv[mf][lst[j]] ? md[mf][lst[j]] : 32'h0;
        if (c) begin
            if (mf < 7) begin
                mclear(mf + 1);
                for (int j = cnt - 1; j >= 0; j--) mpush(mf + 1, vals[j]);
                mf++;
            end
        end else if (r) begin
            if (mf > 0) begin
                mclear(mf);
                mf--;
                for (int j = cnt - 1; j >= 0; j--) mpush(mf, vals[j]);
            end
        end else begin
            for (int p = NR - 1; p >= 0; p--) if (m[p]) mpush(mf, base + p);
        end
        @(posedge clk);
        #1;
        call_i = 1'b0; fret_i = 1'b0; ret_valid_i = '0; xfer_cnt_i = '0;
    endtask

    task automatic chk_reads(int p0, int p1, int p2, int p3, string rq);
        int ps[4];
        ps = '{p0, p1, p2, p3};
        for (int k = 0; k < ND; k++) rd_pos_i[k*PW +: PW] = PW'(ps[k]);
        #1;
        for (int k = 0; k < ND; k++) begin
            bit eok;
            logic [31:0] ed, gd;
            eok = mv[mf][ps[k]];
            ed  = eok ? md[mf][ps[k]] : 32'h0;
            gd  = rd_data_o[k*DW +: DW];
            nchk++;
            if (rd_bad_o[k] !== !eok || gd !== ed) begin
                nfail++;
                $display("FAIL %s port %0d pos %0d: got bad=%0b data=%h, expected bad=%0b data=%h",
                         rq, k, ps[k], rd_bad_o[k], gd, !eok, ed);
            end
        end
    endtask

    task automatic chk_frame(string rq);
        nchk++;
        if (frame_o !== FW'(mf)) begin
            nfail++;
            $display("FAIL %s frame: got %0d, expected %0d", rq, frame_o, mf);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: got hung run, expected completion");
        finish_run();
    end

    initial begin
        for (int f = 0; f < 8; f++) mclear(f);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R11: reset state
        chk_frame("R11");
        chk_reads(0, 1, 2, 3, "R11");
        chk_reads(4, 5, 6, 7, "R11");

        // R6: drop not visible before the edge
        @(negedge clk);
        ret_valid_i = 4'b0001;
        ret_data_i[DW-1:0] = 32'h55;
        chk_reads(0, 0, 1, 0, "R6 before edge");
        @(posedge clk);
        #1 ret_valid_i = '0;
        mpush(0, 32'h55);
        chk_reads(0, 0, 1, 0, "R6 after edge");

        // R1 R2 R3 R4 R5: retire table
        for (int t = 0; t < 10; t++) begin
            step(1'b0, 1'b0, TV[t].mask, TV[t].base, 0, 0, 0, 0, 0);
            chk_reads(int'(TV[t].p0), int'(TV[t].p1), int'(TV[t].p2), int'(TV[t].p3), "R1/R2/R3/R4 table");
        end

        // R7 with R9: call with retires present, repeated list entries
        step(1'b1, 1'b0, 4'b1111, 32'hBAD0, 4, 1, 5, 3, 3);
        chk_frame("R7");
        chk_reads(0, 1, 2, 3, "R7 args");
        chk_reads(4, 5, 7, 0, "R7 callee empty");

        // Callee work, then R8 return with retires ignored (R9)
        step(1'b0, 1'b0, 4'b0011, 32'hA0, 0, 0, 0, 0, 0);
        chk_reads(0, 1, 4, 5, "R3 callee");
        step(1'b0, 1'b1, 4'b1111, 32'hBAD1, 2, 0, 4, 0, 0);
        chk_frame("R8");
        chk_reads(0, 1, 2, 3, "R8 results");
        chk_reads(4, 5, 6, 7, "R8 caller shifted");

        // R9: call and return together, call wins
        step(1'b1, 1'b1, 4'b0000, 32'h0, 1, 7, 0, 0, 0);
        chk_frame("R9");
        chk_reads(0, 1, 0, 0, "R9 call wins");
        // R7: empty position copies as live zero
        step(1'b1, 1'b0, 4'b0000, 32'h0, 2, 0, 5, 0, 0);
        chk_frame("R7 nested");
        chk_reads(0, 1, 2, 0, "R7 empty arg");
        step(1'b0, 1'b1, 4'b0000, 32'h0, 1, 1, 0, 0, 0);
        chk_reads(0, 1, 2, 0, "R8 nested return");
        step(1'b0, 1'b1, 4'b0000, 32'h0, 0, 0, 0, 0, 0);
        chk_frame("R8 zero results");
        chk_reads(0, 1, 2, 3, "R8 zero results");

        // R10: nest to the top frame and back past frame 0
        for (int d = 0; d < 7; d++) step(1'b1, 1'b0, 4'b0000, 32'h0, 0, 0, 0, 0, 0);
        chk_frame("R10 depth");
        step(1'b1, 1'b0, 4'b0001, 32'hBAD2, 1, 0, 0, 0, 0);
        chk_frame("R10 top call");
        chk_reads(0, 1, 2, 3, "R10 top call");
        for (int d = 0; d < 7; d++) step(1'b0, 1'b1, 4'b0000, 32'h0, 0, 0, 0, 0, 0);
        step(1'b0, 1'b1, 4'b0011, 32'hBAD3, 1, 0, 0, 0, 0);
        chk_frame("R10 bottom return");
        chk_reads(0, 1, 2, 3, "R10 caller intact");
        chk_reads(4, 5, 6, 7, "R10 caller intact");

        finish_run();
    end
endmodule